// File: doc/BRIEF.md
# Filtered Egress Packet Counter Bank

This block holds a small bank of packet counters for an egress queueing engine. Every counter owns a filter word and a 32-bit count. Each clock cycle the queueing engine may offer one transmitted-packet event, tagged with its traffic source, its channel, its queue and a DSCP/ring value. Every enabled counter whose filter accepts those tags adds one to its count. A counter can accept several events in a row, and several counters can count the same event.

Software sets up the filters and reads or rewrites the counts through a plain register port. A read returns its data one cycle after the request. Writing a count replaces it, so writing zero clears the counter. The usual setup gives each channel two counters. One counts transmits that came from the CPU and the other counts forwarded transmits. Both leave queue and DSCP/ring open.

The event input is a valid/ready stream. `ev_ready` is low during reset and goes high on the first clock edge after reset. From then on it stays high, so the block never applies back-pressure. An event is taken on any rising edge where both `ev_valid` and `ev_ready` are high. Tags offered while `ev_valid` is low are ignored.

Top module: `egress_pkt_counter_bank`

## Requirements
- R1: While reset is asserted, and right after it, every filter word and every count reads as zero, `reg_rvalid` is 0 and `ev_ready` is 0 during reset.
- R2: Counter n's filter word is at byte address 0x400 + 8·n and its count is at 0x404 + 8·n, for n from 0 to 7. A read request returns `reg_rvalid`=1 with the data in the next cycle. `reg_rdata` is 0 in every cycle where `reg_rvalid` is 0. A misaligned address, or one outside 0x400–0x43F, reads as 0, and a write to it changes nothing.
- R3: Filter word layout: bit 31 enable, bit 30 any channel, bit 29 any queue, bit 28 any DSCP/ring, bits 27:24 source, bits 20:16 DSCP/ring, bits 7:3 channel, bits 2:0 queue. Bits 23:21 and 15:8 always read as zero.
- R4: An accepted event adds one to a counter when the counter is enabled, its source field equals the event source, and each of channel, queue and DSCP/ring is either equal to the event tag or has its any-bit set. Source 0 means CPU-originated and source 1 means forwarded.
- R5: A counter whose enable bit is clear never changes because of events.
- R6: When an any-bit is clear, a mismatch in that one field is enough to block the count, whatever the other fields hold.
- R7: A count of 0xFFFFFFFF that takes one more event becomes 0.
- R8: A write to a count register loads the written value, so writing zero clears it. If the write and a matching event reach the same counter in the same cycle, the written value wins. A filter write takes effect for events from the next cycle on.
- R9: One event can advance every counter it matches in the same cycle.
- R10: After reset `ev_ready` stays high. An event can be accepted on every cycle back to back. Tags offered with `ev_valid` low change no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A packet event is offered |
| ev_ready | output | 1 | The block accepts an event this cycle |
| ev_src | input | 4 | Traffic source of the event |
| ev_chan | input | 5 | Channel tag of the event |
| ev_queue | input | 3 | Queue tag of the event |
| ev_dscp | input | 5 | DSCP/ring tag of the event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |

## Verification
An event accepted at a rising edge changes the count at that same edge. A read issued in the following cycle sees the new count, and its data appears one edge later still. A read issued in the same cycle as the event returns the count from before that edge. A filter write governs events from the next edge on. The bench keeps a behavioural model that steps at every rising edge with the same inputs and records the data each read should return. It compares `reg_rvalid`, `reg_rdata` and `ev_ready` at every falling edge, which is half a cycle after the edge that produced them, so every latency above is checked as it happens.

// File: rtl/ecb_pkg.sv
package ecb_pkg;

  localparam int WORD_W  = 32;
  localparam int SRC_W   = 4;
  localparam int CHAN_W  = 5;
  localparam int QUEUE_W = 3;
  localparam int DSCP_W  = 5;

  // filter word bit positions (software-visible layout)
  localparam int BIT_EN        = 31;
  localparam int BIT_ANY_CHAN  = 30;
  localparam int BIT_ANY_QUEUE = 29;
  localparam int BIT_ANY_DSCP  = 28;
  localparam int SRC_LSB       = 24;
  localparam int DSCP_LSB      = 16;
  localparam int CHAN_LSB      = 3;
  localparam int QUEUE_LSB     = 0;

  typedef struct packed {
    logic                enable;
    logic                any_chan;
    logic                any_queue;
    logic                any_dscp;
    logic [SRC_W-1:0]    src;
    logic [DSCP_W-1:0]   dscp;
    logic [CHAN_W-1:0]   chan;
    logic [QUEUE_W-1:0]  queue;
  } cnt_cfg_t;

  typedef struct packed {
    logic [SRC_W-1:0]    src;
    logic [CHAN_W-1:0]   chan;
    logic [QUEUE_W-1:0]  queue;
    logic [DSCP_W-1:0]   dscp;
  } pkt_tag_t;

  function automatic cnt_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    cnt_cfg_t c;
    c.enable    = w[BIT_EN];
    c.any_chan  = w[BIT_ANY_CHAN];
    c.any_queue = w[BIT_ANY_QUEUE];
    c.any_dscp  = w[BIT_ANY_DSCP];
    c.src       = w[SRC_LSB   +: SRC_W];
    c.dscp      = w[DSCP_LSB  +: DSCP_W];
    c.chan      = w[CHAN_LSB  +: CHAN_W];
    c.queue     = w[QUEUE_LSB +: QUEUE_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input cnt_cfg_t c);
    logic [WORD_W-1:0] w;
    w                         = '0;
    w[BIT_EN]                 = c.enable;
    w[BIT_ANY_CHAN]           = c.any_chan;
    w[BIT_ANY_QUEUE]          = c.any_queue;
    w[BIT_ANY_DSCP]           = c.any_dscp;
    w[SRC_LSB   +: SRC_W]     = c.src;
    w[DSCP_LSB  +: DSCP_W]    = c.dscp;
    w[CHAN_LSB  +: CHAN_W]    = c.chan;
    w[QUEUE_LSB +: QUEUE_W]   = c.queue;
    return w;
  endfunction

endpackage

// File: rtl/ecb_addr_decode.sv
module ecb_addr_decode #(
  parameter int NUM_CNT   = 8,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h400,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic              is_val,
  output logic [IDX_W-1:0]  idx
);
  // each counter occupies an 8-byte pair: filter word, then count
  localparam int              SPAN = 8 * NUM_CNT;
  localparam logic [ADDR_W:0] LO   = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI   = (ADDR_W+1)'(BASE_ADDR + SPAN);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] off;

  assign a_ext  = {1'b0, addr};
  assign off    = a_ext - LO;
  assign sel    = (a_ext >= LO) && (a_ext < HI) && (addr[1:0] == 2'b00);
  assign is_val = off[2];
  assign idx    = IDX_W'(off >> 3);

endmodule

// File: rtl/ecb_filter.sv
module ecb_filter
  import ecb_pkg::*;
(
  input  cnt_cfg_t cfg,
  input  pkt_tag_t tag,
  input  logic     fire,
  output logic     hit
);
  logic src_ok;
  logic chan_ok;
  logic queue_ok;
  logic dscp_ok;

  always_comb begin
    src_ok   = (cfg.src == tag.src);
    chan_ok  = cfg.any_chan  || (cfg.chan  == tag.chan);
    queue_ok = cfg.any_queue || (cfg.queue == tag.queue);
    dscp_ok  = cfg.any_dscp  || (cfg.dscp  == tag.dscp);
  end

  assign hit = fire & cfg.enable & src_ok & chan_ok & queue_ok & dscp_ok;

endmodule

// File: rtl/ecb_counter_slot.sv
module ecb_counter_slot
  import ecb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              val_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              fire,
  input  pkt_tag_t          tag,
  output cnt_cfg_t          cfg_q,
  output logic [CNT_W-1:0]  val_q,
  output logic              hit
);

  ecb_filter u_filt (
    .cfg  (cfg_q),
    .tag  (tag),
    .fire (fire),
    .hit  (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_from_word(wdata);
    end
  end

  // software write has priority over a same-cycle increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (val_we) begin
      val_q <= CNT_W'(wdata);
    end else if (hit) begin
      val_q <= val_q + 1'b1;
    end
  end

endmodule

// File: rtl/egress_pkt_counter_bank.sv
module egress_pkt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_CNT   = 8,
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [3:0]        ev_src,
  input  logic [4:0]        ev_chan,
  input  logic [2:0]        ev_queue,
  input  logic [4:0]        ev_dscp,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic ready_q;
  logic ev_fire;
  pkt_tag_t ev_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign ev_ready = ready_q;
  assign ev_fire  = ev_valid & ready_q;

  always_comb begin
    ev_tag.src   = ev_src;
    ev_tag.chan  = ev_chan;
    ev_tag.queue = ev_queue;
    ev_tag.dscp  = ev_dscp;
  end

  logic             a_sel;
  logic             a_is_val;
  logic [IDX_W-1:0] a_idx;

  ecb_addr_decode #(
    .NUM_CNT   (NUM_CNT),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .IDX_W     (IDX_W)
  ) u_dec (
    .addr   (reg_addr),
    .sel    (a_sel),
    .is_val (a_is_val),
    .idx    (a_idx)
  );

  logic [NUM_CNT-1:0]            cfg_we;
  logic [NUM_CNT-1:0]            val_we;
  logic [NUM_CNT-1:0]            hit_vec;
  logic [NUM_CNT-1:0]            en_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0] val_all;
  cnt_cfg_t                      cfg_all [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
    logic slot_sel;
    assign slot_sel  = a_sel && (a_idx == IDX_W'(g));
    assign cfg_we[g] = reg_wr_en && slot_sel && !a_is_val;
    assign val_we[g] = reg_wr_en && slot_sel &&  a_is_val;
    assign en_vec[g] = cfg_all[g].enable;

    ecb_counter_slot #(
      .CNT_W (CNT_W)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_we (cfg_we[g]),
      .val_we (val_we[g]),
      .wdata  (reg_wdata),
      .fire   (ev_fire),
      .tag    (ev_tag),
      .cfg_q  (cfg_all[g]),
      .val_q  (val_all[g]),
      .hit    (hit_vec[g])
    );
  end

  logic [WORD_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (a_sel && (a_idx == IDX_W'(i))) begin
        rd_word = a_is_val ? WORD_W'(val_all[i]) : cfg_to_word(cfg_all[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd_en;
      reg_rdata  <= reg_rd_en ? rd_word : '0;
    end
  end

endmodule

// File: rtl/ecb_counter_bank_chk.sv
module ecb_counter_bank_chk #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            ev_valid,
  input logic                            ev_ready,
  input logic                            reg_rd_en,
  input logic                            reg_rvalid,
  input logic [31:0]                     reg_wdata,
  input logic [NUM_CNT-1:0]              val_we,
  input logic [NUM_CNT-1:0]              hit_vec,
  input logic [NUM_CNT-1:0]              en_vec,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   val_all
);

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);

  assert_no_spurious_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rvalid);

  assert_ready_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ev_ready);

  assert_no_hit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_ready) |-> (hit_vec == '0));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec[i] && !val_we[i]) |=> (val_all[i] == $past(val_all[i]) + 1'b1));

    assert_hold_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_vec[i] && !val_we[i]) |=> $stable(val_all[i]));

    assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_vec[i] |-> en_vec[i]);

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      val_we[i] |=> (val_all[i] == CNT_W'($past(reg_wdata))));
  end

endmodule

bind egress_pkt_counter_bank ecb_counter_bank_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .reg_rd_en  (reg_rd_en),
  .reg_rvalid (reg_rvalid),
  .reg_wdata  (reg_wdata),
  .val_we     (val_we),
  .hit_vec    (hit_vec),
  .en_vec     (en_vec),
  .val_all    (val_all)
);

// File: tb/tb_egress_pkt_counter_bank.sv
module tb_egress_pkt_counter_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCNT       = 8;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [3:0]  ev_src = '0;
  logic [4:0]  ev_chan = '0;
  logic [2:0]  ev_queue = '0;
  logic [4:0]  ev_dscp = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  egress_pkt_counter_bank dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_src(ev_src), .ev_chan(ev_chan), .ev_queue(ev_queue), .ev_dscp(ev_dscp),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
  );

  // ---------------- reference model ----------------
  logic [31:0] cfg_m [NCNT];
  logic [31:0] val_m [NCNT];
  bit          ready_m = 1'b0;
  bit          exp_rvalid = 1'b0;
  logic [31:0] exp_rdata = '0;
  string       cur_tag = "R1";
  string       exp_tag = "R1";
  int          n_chk = 0;
  int          n_err = 0;
  bit          checking = 1'b0;
  bit          done = 1'b0;
  int          cycles = 0;

  function automatic int map_addr(input logic [11:0] a);
    int off;
    if (a[1:0] != 2'b00) return -1;
    off = int'(a) - 'h400;
    if (off < 0 || off >= 8*NCNT) return -1;
    return (off/8)*2 + (((off%8) == 4) ? 1 : 0);
  endfunction

  always @(posedge clk) begin : model
    int k;
    bit acc;
    bit m;
    logic [31:0] c;
    exp_tag = cur_tag;
    if (!rst_n) begin
      for (int i = 0; i < NCNT; i++) begin
        cfg_m[i] = '0;
        val_m[i] = '0;
      end
      ready_m    = 1'b0;
      exp_rvalid = 1'b0;
      exp_rdata  = '0;
    end else begin
      k = map_addr(reg_addr);
      exp_rvalid = reg_rd_en;
      exp_rdata  = '0;
      if (reg_rd_en && k >= 0)
        exp_rdata = (k % 2 == 1) ? val_m[k/2] : cfg_m[k/2];
      acc = ev_valid && ready_m;
      for (int i = 0; i < NCNT; i++) begin
        c = cfg_m[i];
        m = acc && c[31] && (c[27:24] == ev_src)
            && (c[30] || c[7:3] == ev_chan)
            && (c[29] || c[2:0] == ev_queue)
            && (c[28] || c[20:16] == ev_dscp);
        if (reg_wr_en && k == 2*i+1) val_m[i] = reg_wdata;
        else if (m)                  val_m[i] = val_m[i] + 32'd1;
      end
      if (reg_wr_en && k >= 0 && (k % 2 == 0))
        cfg_m[k/2] = reg_wdata & 32'hFF1F_00FF;
      ready_m = 1'b1;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      chk(exp_tag, "read valid", {31'b0, reg_rvalid}, {31'b0, exp_rvalid});
      chk(exp_tag, "read data", reg_rdata, exp_rdata);
      chk("R10", "event ready", {31'b0, ev_ready}, {31'b0, ready_m});
    end
  end

  task automatic report();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog: actual %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
      report();
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(input bit wr, input bit rd, input logic [11:0] a,
                       input logic [31:0] d, input bit v, input logic [3:0] s,
                       input logic [4:0] ch, input logic [2:0] q, input logic [4:0] ds);
    @(negedge clk);
    reg_wr_en = wr; reg_rd_en = rd; reg_addr = a; reg_wdata = d;
    ev_valid = v; ev_src = s; ev_chan = ch; ev_queue = q; ev_dscp = ds;
  endtask

  task automatic idle();
    drive(0, 0, 12'h0, 32'h0, 0, 4'h0, 5'h0, 3'h0, 5'h0);
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    drive(1, 0, a, d, 0, 4'h0, 5'h0, 3'h0, 5'h0);
  endtask

  task automatic rd_reg(input logic [11:0] a);
    drive(0, 1, a, 32'h0, 0, 4'h0, 5'h0, 3'h0, 5'h0);
  endtask

  task automatic ev(input logic [3:0] s, input logic [4:0] ch,
                    input logic [2:0] q, input logic [4:0] ds);
    drive(0, 0, 12'h0, 32'h0, 1, s, ch, q, ds);
  endtask

  task automatic rd_all();
    for (int n = 0; n < 2*NCNT; n++) rd_reg(12'(12'h400 + 4*n));
  endtask

  function automatic logic [11:0] cfg_addr(input int n);
    return 12'(12'h400 + 8*n);
  endfunction

  function automatic logic [11:0] val_addr(input int n);
    return 12'(12'h404 + 8*n);
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    checking = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    cur_tag = "R1";
    rd_all();

    // R3: reserved bits read as zero, fields keep their positions
    cur_tag = "R3";
    wr_reg(cfg_addr(0), 32'hFFFF_FFFF);
    rd_reg(cfg_addr(0));
    wr_reg(cfg_addr(0), 32'h0A15_0A5A);
    rd_reg(cfg_addr(0));
    wr_reg(cfg_addr(0), 32'h0);

    // R4: per-channel pair setup, CPU (src 0) and forwarded (src 1)
    cur_tag = "R4";
    for (int c = 0; c < 4; c++) begin
      wr_reg(cfg_addr(2*c),   32'hB000_0000 | (c << 3));
      wr_reg(cfg_addr(2*c+1), 32'hB100_0000 | (c << 3));
    end
    ev(4'd0, 5'd0, 3'd3, 5'd7);
    ev(4'd1, 5'd2, 3'd0, 5'd31);
    ev(4'd0, 5'd3, 3'd6, 5'd1);
    ev(4'd1, 5'd1, 3'd2, 5'd4);
    ev(4'd1, 5'd1, 3'd7, 5'd9);
    ev(4'd0, 5'd4, 3'd1, 5'd2);
    ev(4'd2, 5'd0, 3'd1, 5'd2);
    idle();
    rd_all();

    // R6: exact filter on counter 7, one field off at a time
    cur_tag = "R6";
    wr_reg(val_addr(7), 32'h0);
    wr_reg(cfg_addr(7), 32'h8109_001D);
    ev(4'd1, 5'd3, 3'd5, 5'd9);
    ev(4'd1, 5'd3, 3'd5, 5'd8);
    ev(4'd1, 5'd3, 3'd4, 5'd9);
    ev(4'd1, 5'd2, 3'd5, 5'd9);
    ev(4'd0, 5'd3, 3'd5, 5'd9);
    idle();
    rd_reg(val_addr(7));
    wr_reg(cfg_addr(7), 32'hC109_001D);
    ev(4'd1, 5'd2, 3'd5, 5'd9);
    idle();
    rd_reg(val_addr(7));

    // R5: disabled counter with open filter does not move
    cur_tag = "R5";
    wr_reg(cfg_addr(6), 32'h7000_0000);
    ev(4'd0, 5'd3, 3'd1, 5'd1);
    ev(4'd0, 5'd9, 3'd2, 5'd0);
    idle();
    rd_reg(val_addr(6));
    rd_reg(cfg_addr(6));

    // R9: two counters share one event
    cur_tag = "R9";
    wr_reg(cfg_addr(0), 32'hF000_0000);
    wr_reg(cfg_addr(1), 32'hF000_0000);
    wr_reg(val_addr(0), 32'h0);
    wr_reg(val_addr(1), 32'h0);
    ev(4'd0, 5'd17, 3'd3, 5'd3);
    idle();
    rd_reg(val_addr(0));
    rd_reg(val_addr(1));

    // R7: wrap past all ones
    cur_tag = "R7";
    wr_reg(val_addr(0), 32'hFFFF_FFFE);
    ev(4'd0, 5'd1, 3'd1, 5'd1);
    idle();
    rd_reg(val_addr(0));
    ev(4'd0, 5'd1, 3'd1, 5'd1);
    idle();
    rd_reg(val_addr(0));

    // R8: write beats a same-cycle increment, zero clears, filter write timing
    cur_tag = "R8";
    drive(1, 0, val_addr(1), 32'h0000_1234, 1, 4'd0, 5'd0, 3'd0, 5'd0);
    idle();
    rd_reg(val_addr(1));
    drive(1, 1, val_addr(1), 32'h0, 1, 4'd0, 5'd0, 3'd0, 5'd0);
    rd_reg(val_addr(1));
    drive(1, 0, cfg_addr(2), 32'hF000_0000, 1, 4'd0, 5'd0, 3'd0, 5'd0);
    ev(4'd0, 5'd0, 3'd0, 5'd0);
    idle();
    rd_reg(val_addr(2));

    // R10: ignored tags without valid, then back-to-back events
    cur_tag = "R10";
    wr_reg(val_addr(0), 32'h0);
    drive(0, 0, 12'h0, 32'h0, 0, 4'd0, 5'd1, 3'd1, 5'd1);
    drive(0, 0, 12'h0, 32'h0, 0, 4'd0, 5'd2, 3'd2, 5'd2);
    rd_reg(val_addr(0));
    for (int n = 0; n < 5; n++) ev(4'd0, 5'(n), 3'(n), 5'(n));
    idle();
    rd_reg(val_addr(0));

    // R2: unmapped and misaligned addresses
    cur_tag = "R2";
    rd_reg(12'h3FC);
    rd_reg(12'h440);
    rd_reg(12'h401);
    rd_reg(12'h406);
    wr_reg(12'h440, 32'hDEAD_BEEF);
    wr_reg(12'h3F8, 32'hFFFF_FFFF);
    wr_reg(12'h405, 32'h5555_5555);
    rd_all();

    // R4: mixed random traffic against the model
    cur_tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom_range(0, 9) == 0), ($urandom_range(0, 2) == 0),
            12'(12'h3F8 + 4*$urandom_range(0, 20)),
            ($urandom_range(0, 1) == 1) ? $urandom : ($urandom & 32'hF000_001F),
            ($urandom_range(0, 3) != 0),
            4'($urandom_range(0, 2)), 5'($urandom_range(0, 5)),
            3'($urandom_range(0, 3)), 5'($urandom_range(0, 3)));
    end
    idle();
    rd_all();
    idle();
    repeat (3) @(negedge clk);
    report();
  end

endmodule